// File: doc/BRIEF.md
# Fault-Injectable Concentrating Switch Array

This block is a grid of 2x2 switching elements that gathers fixed-size cells arriving on `N` input rows onto a smaller set of `L` output links belonging to one output group. Rows are scanned in priority order, row 0 first. Each row's cell travels east through the columns in order, column 0 first. A cell marked for the group drops south onto the first link that is still free. A cell that is still moving east after the last column is lost, and the block raises a discard flag for that row.

Every element holds a 3-bit fault code that software can load through a write port. The code can make the element behave as a healthy switch, freeze it in the straight-through or the exchange state, or tie the data on its vertical or horizontal exit to a constant. This lets a test environment reproduce the cell loss, misrouting and data corruption that a defective element causes. All elements start healthy after reset.

The whole grid settles within one cell slot. The link outputs and the discard flags are registered, so they appear one clock after the cells are sampled.

Top module: `fault_switch_array`

## Requirements
- R1: With no element frozen (codes 0, 3, 4, 5, 6, 7 only), each valid cell with its match bit set takes the lowest-numbered free link it reaches. Rows are served in order from row 0, so the valid links always form a contiguous block from link 0, and their count is the smaller of L and the number of such cells.
- R2: `drop[i]` is 1 exactly when row i's cell (or a cell diverted into row i) leaves the last column valid and matching. A row whose cell is invalid, or whose match bit is 0, never raises `drop` without diversion, and a non-matching cell never occupies a link as valid.
- R3: Code 1 (cross-stuck) passes the north input to the south and the west input to the east, ignoring the cell. A cross-stuck element in a middle column only delays the row's cell to a later column.
- R4: A cross-stuck element in the last column loses a cell only when that cell would otherwise have won the last link. When demand exceeds L, the number of discarded cells does not change.
- R5: Code 2 (toggle-stuck) always connects the west input to the south link and marks the link occupied, even when the west input carries no matching cell; such a link shows `link_vld` 0 and blocks later rows. A cell already on the north link is diverted east into the faulty row.
- R6: Code 3 forces every data bit leaving the element southward to 0, and code 4 forces it to 1. Routing is unchanged.
- R7: Code 5 forces every data bit leaving the element eastward to 0, and code 6 forces it to 1. Routing is unchanged.
- R8: A configuration write at a clock edge applies to cells sampled from the next edge onward. Reset returns every element to code 0. Code 7 behaves as code 0.
- R9: Outputs register one clock after the input cells are sampled. During reset, `link_vld` and `drop` are 0.
- R10: No matching cell is created or lost silently: each cycle, the number of valid links plus the number of discard flags equals the number of valid matching input cells of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | N | Row carries a cell this slot |
| in_match | input | N | Row's cell is destined for this output group |
| in_data | input | N*W | Cell data, row i in bits [i*W +: W] |
| cfg_we | input | 1 | Write enable for the fault code store |
| cfg_row | input | RW | Row of the element to write |
| cfg_col | input | CW | Column of the element to write |
| cfg_code | input | 3 | 0 normal, 1 cross, 2 toggle, 3/4 vertical stuck 0/1, 5/6 horizontal stuck 0/1, 7 normal |
| link_vld | output | L | Link carries a valid matching cell |
| link_data | output | L*W | Link data, link j in bits [j*W +: W]; don't care where `link_vld` is 0 |
| drop | output | N | Row's cell was discarded this slot |

## Verification
Several demand patterns are used, and each separates a different kind of fault:
- Sparse demand (fewer cells than links) shows whether a link was wasted.
- Exactly L cells make a last-column cross-stuck element cost a cell.
- Excess demand shows that the total loss stays the same when only the identity of the losing row changes.
- A toggle element sitting under a link that is already taken shows that the north cell is diverted rather than destroyed.
- Stuck-data codes are driven with data patterns whose bits differ from both constants, so corruption is visible on every bit.

Random slots with randomly placed fault codes in every column are compared against a bench model.

// File: rtl/fault_switch_array.sv
module fault_switch_array #(
  parameter int N  = 8,
  parameter int L  = 4,
  parameter int W  = 8,
  parameter int RW = $clog2(N),
  parameter int CW = (L > 1) ? $clog2(L) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   in_vld,
  input  logic [N-1:0]   in_match,
  input  logic [N*W-1:0] in_data,
  input  logic           cfg_we,
  input  logic [RW-1:0]  cfg_row,
  input  logic [CW-1:0]  cfg_col,
  input  logic [2:0]     cfg_code,
  output logic [L-1:0]   link_vld,
  output logic [L*W-1:0] link_data,
  output logic [N-1:0]   drop
);
  logic [2:0]   cfg [N][L];
  logic [L-1:0] occ, lv;
  logic [W-1:0] ld [L];
  logic [N-1:0] dr;
  logic         rv, rm, no, nv, plain;
  logic [W-1:0] rd, nd;
  logic [2:0]   code;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < L; j++) cfg[i][j] <= 3'd0;
    end else if (cfg_we && int'(cfg_row) < N && int'(cfg_col) < L) begin
      cfg[cfg_row][cfg_col] <= cfg_code;
    end
  end

  always_comb begin
    occ = '0; lv = '0; dr = '0; plain = 1'b1;
    rv = 1'b0; rm = 1'b0; rd = '0; no = 1'b0; nv = 1'b0; nd = '0; code = 3'd0;
    for (int j = 0; j < L; j++) ld[j] = '0;
    for (int i = 0; i < N; i++) begin
      rv = in_vld[i]; rm = in_match[i]; rd = in_data[i*W +: W];
      for (int j = 0; j < L; j++) begin
        code = cfg[i][j];
        no = occ[j]; nv = lv[j]; nd = ld[j];
        if (code == 3'd1) begin
          plain = 1'b0;
        end else if (code == 3'd2) begin
          plain = 1'b0;
          occ[j] = 1'b1; lv[j] = rv & rm; ld[j] = rd;
          rv = nv; rm = nv; rd = nd;
        end else begin
          if (!no && rv && rm) begin
            occ[j] = 1'b1; lv[j] = 1'b1; ld[j] = rd;
            rv = 1'b0; rm = 1'b0;
          end
          if (code == 3'd3 || code == 3'd4) ld[j] = {W{code == 3'd4}};
          if (code == 3'd5 || code == 3'd6) rd = {W{code == 3'd6}};
        end
      end
      dr[i] = rv & rm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_vld <= '0;
      drop     <= '0;
      link_data <= '0;
    end else begin
      link_vld <= lv;
      drop     <= dr;
      for (int j = 0; j < L; j++) link_data[j*W +: W] <= ld[j];
    end
  end

  logic         live;
  logic [N-1:0] want;
  assign want = in_vld & in_match;
  always_ff @(posedge clk) live <= !rst;

  // R10
  cell_conservation_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> ($countones(link_vld) + $countones(drop)) == $past($countones(want)));

  // R1
  link_count_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(plain) |-> $countones(link_vld) ==
      (($past($countones(want)) > L) ? L : $past($countones(want))));

  // R1
  link_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(plain) |-> (link_vld & (link_vld + L'(1))) == '0);

  // R2
  drop_demand_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(plain) |-> (drop & ~$past(want)) == '0);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) && live == 1'b0 && $past(live) == 1'b0 |-> link_vld == '0 && drop == '0);
endmodule

// File: tb/tb_fault_switch_array.sv
`timescale 1ns/1ps
module tb_fault_switch_array;
  localparam int N = 8, L = 4, W = 8, RW = 3, CW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0]   in_vld = '0, in_match = '0;
  logic [N*W-1:0] in_data = '0;
  logic           cfg_we = 1'b0;
  logic [RW-1:0]  cfg_row = '0;
  logic [CW-1:0]  cfg_col = '0;
  logic [2:0]     cfg_code = '0;
  logic [L-1:0]   link_vld;
  logic [L*W-1:0] link_data;
  logic [N-1:0]   drop;

  int tests = 0, fails = 0;
  logic [2:0]   mcfg [N][L];
  logic [L-1:0] e_lv;
  logic [W-1:0] e_ld [L];
  logic [N-1:0] e_dr;

  fault_switch_array #(.N(N), .L(L), .W(W), .RW(RW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_match(in_match), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_code(cfg_code),
    .link_vld(link_vld), .link_data(link_data), .drop(drop));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(input int j);
    return link_data[j*W +: W];
  endfunction

  // bench model: walks each row along the columns
  task automatic model(input logic [N-1:0] v, input logic [N-1:0] m, input logic [N*W-1:0] d);
    logic [L-1:0] busy;
    busy = '0; e_lv = '0; e_dr = '0;
    for (int j = 0; j < L; j++) e_ld[j] = '0;
    for (int i = 0; i < N; i++) begin
      logic cv, cm; logic [W-1:0] cd;
      cv = v[i]; cm = m[i]; cd = d[i*W +: W];
      for (int j = 0; j < L; j++) begin
        case (mcfg[i][j])
          3'd1: ;
          3'd2: begin
            logic pv; logic [W-1:0] pd;
            pv = e_lv[j]; pd = e_ld[j];
            busy[j] = 1'b1; e_lv[j] = cv && cm; e_ld[j] = cd;
            cv = pv; cm = pv; cd = pd;
          end
          default: begin
            if (cv && cm && !busy[j]) begin
              busy[j] = 1'b1; e_lv[j] = 1'b1; e_ld[j] = cd; cv = 1'b0; cm = 1'b0;
            end
            if (mcfg[i][j] == 3'd3) e_ld[j] = '0;
            if (mcfg[i][j] == 3'd4) e_ld[j] = '1;
            if (mcfg[i][j] == 3'd5) cd = '0;
            if (mcfg[i][j] == 3'd6) cd = '1;
          end
        endcase
      end
      e_dr[i] = cv && cm;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = '0; in_match = '0; cfg_we = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 reset link_vld", link_vld, 0);
    chk("R9 reset drop", drop, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) for (int j = 0; j < L; j++) mcfg[i][j] = 3'd0;
  endtask

  task automatic wcfg(input int r, input int c, input logic [2:0] code);
    @(negedge clk);
    in_vld = '0; cfg_we = 1'b1; cfg_row = RW'(r); cfg_col = CW'(c); cfg_code = code;
    @(posedge clk); #1;
    @(negedge clk); cfg_we = 1'b0;
    mcfg[r][c] = code;
  endtask

  task automatic slot(input logic [N-1:0] v, input logic [N-1:0] m, input string req);
    @(negedge clk);
    in_vld = v; in_match = m;
    @(posedge clk); #1;
    model(v, m, in_data);
    chk(req, link_vld, e_lv);
    chk(req, drop, e_dr);
    for (int j = 0; j < L; j++) if (e_lv[j]) chk(req, lane(j), e_ld[j]);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) in_data[i*W +: W] = W'(8'h10 + i);
    do_reset();

    // R1 sparse demand fills a prefix of links
    slot(8'b0100_1010, 8'hFF, "R1 model");
    chk("R1 sparse links", link_vld, 4'b0111);
    chk("R1 link0 row1", lane(0), 8'h11);
    chk("R1 link2 row6", lane(2), 8'h16);

    // R2 excess demand, row 6 valid but not matching
    slot(8'b0111_1111, 8'b0011_1111, "R2 model");
    chk("R2 excess drop", drop, 8'b0011_0000);
    chk("R2 link3 row3", lane(3), 8'h13);

    // R4 cross-stuck in last column
    wcfg(3, 3, 3'd1);
    slot(8'b0000_1111, 8'hFF, "R4 model");
    chk("R4 exact demand loses row3", drop, 8'b0000_1000);
    chk("R4 exact demand links", link_vld, 4'b0111);
    slot(8'b0011_1111, 8'hFF, "R4 model");
    chk("R4 excess demand drop", drop, 8'b0010_1000);
    chk("R4 excess demand count", 64'($countones(drop)), 2);
    chk("R4 link3 row4", lane(3), 8'h14);

    // R3 cross-stuck in middle column delays row0
    do_reset();
    wcfg(0, 0, 3'd1);
    slot(8'b0000_0011, 8'hFF, "R3 model");
    chk("R3 mid links", link_vld, 4'b0011);
    chk("R3 link0 row1", lane(0), 8'h11);
    chk("R3 link1 row0", lane(1), 8'h10);

    // R5 toggle-stuck wastes a link
    do_reset();
    wcfg(1, 1, 3'd2);
    slot(8'b0001_1101, 8'hFF, "R5 model");
    chk("R5 wasted link", link_vld, 4'b1101);
    chk("R5 later row lost", drop, 8'b0001_0000);
    // R5 toggle-stuck in last column
    do_reset();
    wcfg(2, 3, 3'd2);
    slot(8'b0000_1111, 8'hFF, "R5 model");
    chk("R5 last col links", link_vld, 4'b0111);
    chk("R5 last col drop", drop, 8'b0000_1000);
    // R5 north cell diverted east
    do_reset();
    wcfg(2, 0, 3'd2);
    slot(8'b0000_0111, 8'hFF, "R5 model");
    chk("R5 divert links", link_vld, 4'b0111);
    chk("R5 divert link0 row2", lane(0), 8'h12);
    chk("R5 divert link2 row0", lane(2), 8'h10);
    chk("R5 divert no drop", drop, 0);

    // R6 vertical stuck
    do_reset();
    in_data[0 +: W] = 8'h5A; in_data[W +: W] = 8'hA5;
    wcfg(0, 0, 3'd4);
    wcfg(1, 1, 3'd3);
    slot(8'b0000_0011, 8'hFF, "R6 model");
    chk("R6 vstuck1 link0", lane(0), 8'hFF);
    chk("R6 vstuck0 link1", lane(1), 8'h00);

    // R7 horizontal stuck
    do_reset();
    wcfg(1, 0, 3'd5);
    slot(8'b0000_0011, 8'hFF, "R7 model");
    chk("R7 hstuck0 link1", lane(1), 8'h00);
    chk("R7 hstuck0 link0 clean", lane(0), 8'h5A);
    wcfg(1, 0, 3'd6);
    slot(8'b0000_0011, 8'hFF, "R7 model");
    chk("R7 hstuck1 link1", lane(1), 8'hFF);

    // R8 write applies from the next slot
    do_reset();
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 0; cfg_col = 0; cfg_code = 3'd1;
    in_vld = 8'b0000_0001; in_match = 8'hFF;
    @(posedge clk); #1;
    chk("R8 same slot old code", link_vld, 4'b0001);
    @(negedge clk); cfg_we = 1'b0; mcfg[0][0] = 3'd1;
    @(posedge clk); #1;
    chk("R8 next slot new code", link_vld, 4'b0010);
    wcfg(0, 0, 3'd7);
    slot(8'b0000_0001, 8'hFF, "R8 model");
    chk("R8 code7 normal", link_vld, 4'b0001);

    // random phase
    do_reset();
    begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
    end
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(3) == 0) begin
        int r, c; logic [2:0] code;
        r = $urandom_range(N-1); c = $urandom_range(L-1);
        code = ($urandom_range(1) == 0) ? 3'd0 : 3'($urandom_range(7));
        wcfg(r, c, code);
      end
      for (int i = 0; i < N; i++) in_data[i*W +: W] = W'($urandom);
      slot(N'($urandom), N'($urandom | $urandom), "R1 R3 R5 R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule